// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block stands in for one NOR-style flash bank while it carries out an embedded byte program or a sector erase. It also answers reads of the bank during that time. A program start carries an address and a byte. An erase start carries a mask of the sectors to clear. A level-sensitive suspend input parks a running erase. A per-sector protection mask decides which targets may actually change. The array is a small register file inside the block.

When the bank is idle, a read returns the stored byte. While an operation runs, a read returns a polling byte. Its top bit depends on the operation type, and during a suspended erase also on the sector read. The other seven bits read as zero. A host polls that bit and the active-low ready/busy line to learn when the operation has finished.

The cycle after completion is a settling read window. In that window only the top bit shows the final data. Full data follows on the next read. Operation lengths are counted in clock cycles and set by parameters.

Top module: `flash_status_resp`

## Requirements
- R1: After reset, `ready_n` is 1, `rd_data` is 0x00, and array byte A holds (A*37+5) mod 256.
- R2: A read has one cycle of latency. When `rd_oe` is high at a clock edge, `rd_data` after that edge holds the byte selected for the state before the edge. When `rd_oe` is low at the edge, `rd_data` becomes 0x00. In the idle state that byte is the array byte at `rd_addr`.
- R3: `ready_n` is 0 for exactly PROG_CYC cycles after an accepted program start on an unprotected sector. It is 0 for exactly ERASE_CYC cycles after an accepted erase start with at least one unprotected selected sector. In both cases the low time starts right after the edge that samples the start.
- R4: While a program runs, a read at any address returns {~d7, 7'b0}, where d7 is bit 7 of the byte being programmed.
- R5: While an erase runs and is not suspended, a read at any address returns 0x00.
- R6: For one cycle after a program or erase finishes, a read returns {bit 7 of the stored byte at `rd_addr`, 7'b0}. From the next cycle on, reads return the full stored byte.
- R7: A program whose sector is protected holds `ready_n` low for PROT_PROG_CYC cycles and shows R4 status. The array is left unchanged.
- R8: An erase whose selected sectors are all protected holds `ready_n` low for PROT_ERASE_CYC cycles and reads 0x00 meanwhile. The array is left unchanged.
- R9: At the end of an erase, every byte in a selected and unprotected sector becomes 0xFF. Bytes in protected or unselected sectors keep their value. The sector of an address is its top SECT_W bits.
- R10: If `susp_req` is high at an edge during an erase, the erase is suspended from the next cycle. While suspended, `ready_n` is 1 and the erase counter holds. A read in a selected sector returns 0x80, and a read elsewhere returns array data. Once `susp_req` is low, the erase resumes and finishes its remaining cycles.
- R11: During suspend, a program start to a sector not selected by the erase is accepted. It follows R3, R4 and R7, then returns to the suspended state. A program start to a selected sector is ignored and `ready_n` stays 1.
- R12: Starts are accepted only when the bank is idle; any start arriving while an operation runs or settles is ignored. If both starts arrive together in idle, the program wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_start | input | 1 | Program start pulse |
| prog_addr | input | ADDR_W | Byte address to program |
| prog_data | input | 8 | Byte to program |
| erase_start | input | 1 | Erase start pulse |
| erase_sel | input | 2**SECT_W | Sectors selected for erase |
| susp_req | input | 1 | Level request to suspend a running erase |
| prot_mask | input | 2**SECT_W | Per-sector write protection |
| rd_oe | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read byte |
| ready_n | output | 1 | Low while an embedded operation runs |

## Verification
A wrong operation state shows up on the polling bit of the very next read. It also shows up in the length of the `ready_n` low window, which the bench counts cycle by cycle against the parameter.

A program that wrongly changes a protected byte can also be caught. So can an erase that reaches the wrong sector, or an ignored start that was taken anyway. Each of these is caught once the bank settles, by the readback of the affected bytes.

A suspend counter that keeps running would show as a shortened resumed busy window. A status mux that ignores the selected sectors would return array data instead of 0x80 during suspend.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_ESUSP,
        ST_SPROG,
        ST_SETTLE
    } fsr_state_e;

    typedef struct packed {
        logic       poll;
        logic [6:0] rest;
    } poll_byte_t;

    function automatic logic [7:0] init_byte(input int a);
        int v;
        v = a * 37 + 5;
        return v[7:0];
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic                    ers_en,
    input  logic [(1<<SECT_W)-1:0]  ers_mask,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [7:0]              rd_byte
);
    import fsr_pkg::*;

    localparam int NBYTES = 1 << ADDR_W;
    localparam int SH     = ADDR_W - SECT_W;

    logic [NBYTES-1:0][7:0] cells;

    for (genvar g = 0; g < NBYTES; g++) begin : g_cell
        logic [7:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= init_byte(g);
            end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                cell_q <= wr_data;
            end else if (ers_en && ers_mask[g >> SH]) begin
                cell_q <= 8'hFF;
            end
        end
        assign cells[g] = cell_q;
    end

    assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/fsr_rdmux.sv
module fsr_rdmux #(
    parameter int SECT_W = 2
) (
    input  fsr_pkg::fsr_state_e      state,
    input  logic [SECT_W-1:0]        rd_sect,
    input  logic [7:0]               arr_byte,
    input  logic                     pdata7,
    input  logic [(1<<SECT_W)-1:0]   esel,
    output logic [7:0]               mux_byte
);
    import fsr_pkg::*;

    poll_byte_t pb;

    always_comb begin
        pb = '{poll: arr_byte[7], rest: arr_byte[6:0]};
        case (state)
            ST_PROG, ST_SPROG: pb = '{poll: ~pdata7, rest: 7'd0};
            ST_ERASE:          pb = '{poll: 1'b0, rest: 7'd0};
            ST_ESUSP: begin
                if (esel[rd_sect]) pb = '{poll: 1'b1, rest: 7'd0};
            end
            ST_SETTLE:         pb.rest = 7'd0;
            default: ;
        endcase
    end

    assign mux_byte = pb;
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp #(
    parameter int ADDR_W         = 6,
    parameter int SECT_W         = 2,
    parameter int PROG_CYC       = 16,
    parameter int ERASE_CYC      = 40,
    parameter int PROT_PROG_CYC  = 6,
    parameter int PROT_ERASE_CYC = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    prog_start,
    input  logic [ADDR_W-1:0]       prog_addr,
    input  logic [7:0]              prog_data,
    input  logic                    erase_start,
    input  logic [(1<<SECT_W)-1:0]  erase_sel,
    input  logic                    susp_req,
    input  logic [(1<<SECT_W)-1:0]  prot_mask,
    input  logic                    rd_oe,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [7:0]              rd_data,
    output logic                    ready_n
);
    import fsr_pkg::*;

    localparam int NSECT = 1 << SECT_W;
    localparam int MAXC  = max2(max2(PROG_CYC, ERASE_CYC), max2(PROT_PROG_CYC, PROT_ERASE_CYC));
    localparam int TW    = $clog2(MAXC + 1);

    fsr_state_e        state_q, state_d;
    logic [ADDR_W-1:0] paddr_q;
    logic [7:0]        pdata_q;
    logic              pprot_q;
    logic [NSECT-1:0]  esel_q, eeff_q;

    logic              cap_prog, cap_erase;
    logic              p_load, p_dec, p_zero;
    logic              e_load, e_dec, e_zero;
    logic [TW-1:0]     p_val, e_val;
    logic              wr_en, ers_en;
    logic [SECT_W-1:0] psect;
    logic              prog_prot_in;
    logic [NSECT-1:0]  eeff_in;
    logic [7:0]        arr_byte, mux_byte;

    assign psect        = prog_addr[ADDR_W-1 -: SECT_W];
    assign prog_prot_in = prot_mask[psect];
    assign eeff_in      = erase_sel & ~prot_mask;
    assign p_val        = prog_prot_in ? TW'(PROT_PROG_CYC - 1) : TW'(PROG_CYC - 1);
    assign e_val        = (eeff_in == '0) ? TW'(PROT_ERASE_CYC - 1) : TW'(ERASE_CYC - 1);

    always_comb begin
        state_d   = state_q;
        cap_prog  = 1'b0;
        cap_erase = 1'b0;
        p_load    = 1'b0;
        p_dec     = 1'b0;
        e_load    = 1'b0;
        e_dec     = 1'b0;
        wr_en     = 1'b0;
        ers_en    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (prog_start) begin
                    cap_prog = 1'b1;
                    p_load   = 1'b1;
                    state_d  = ST_PROG;
                end else if (erase_start) begin
                    cap_erase = 1'b1;
                    e_load    = 1'b1;
                    state_d   = ST_ERASE;
                end
            end
            ST_PROG: begin
                if (p_zero) begin
                    wr_en   = ~pprot_q;
                    state_d = ST_SETTLE;
                end else begin
                    p_dec = 1'b1;
                end
            end
            ST_ERASE: begin
                if (susp_req) begin
                    state_d = ST_ESUSP;
                end else if (e_zero) begin
                    ers_en  = |eeff_q;
                    state_d = ST_SETTLE;
                end else begin
                    e_dec = 1'b1;
                end
            end
            ST_ESUSP: begin
                if (prog_start && !esel_q[psect]) begin
                    cap_prog = 1'b1;
                    p_load   = 1'b1;
                    state_d  = ST_SPROG;
                end else if (!susp_req) begin
                    state_d = ST_ERASE;
                end
            end
            ST_SPROG: begin
                if (p_zero) begin
                    wr_en   = ~pprot_q;
                    state_d = ST_ESUSP;
                end else begin
                    p_dec = 1'b1;
                end
            end
            ST_SETTLE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            paddr_q <= '0;
            pdata_q <= '0;
            pprot_q <= 1'b0;
            esel_q  <= '0;
            eeff_q  <= '0;
            rd_data <= '0;
        end else begin
            state_q <= state_d;
            if (cap_prog) begin
                paddr_q <= prog_addr;
                pdata_q <= prog_data;
                pprot_q <= prog_prot_in;
            end
            if (cap_erase) begin
                esel_q <= erase_sel;
                eeff_q <= eeff_in;
            end
            rd_data <= rd_oe ? mux_byte : 8'h00;
        end
    end

    assign ready_n = !(state_q == ST_PROG || state_q == ST_ERASE || state_q == ST_SPROG);

    fsr_timer #(.TW(TW)) prog_tmr_i (
        .clk(clk), .rst(rst), .load(p_load), .load_val(p_val), .dec(p_dec), .zero(p_zero)
    );

    fsr_timer #(.TW(TW)) erase_tmr_i (
        .clk(clk), .rst(rst), .load(e_load), .load_val(e_val), .dec(e_dec), .zero(e_zero)
    );

    fsr_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) array_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(paddr_q), .wr_data(pdata_q),
        .ers_en(ers_en), .ers_mask(eeff_q),
        .rd_addr(rd_addr), .rd_byte(arr_byte)
    );

    fsr_rdmux #(.SECT_W(SECT_W)) rdmux_i (
        .state(state_q), .rd_sect(rd_addr[ADDR_W-1 -: SECT_W]), .arr_byte(arr_byte),
        .pdata7(pdata_q[7]), .esel(esel_q), .mux_byte(mux_byte)
    );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker (
    input logic                clk,
    input logic                rst,
    input fsr_pkg::fsr_state_e st,
    input logic                rd_oe,
    input logic [7:0]          rd_data,
    input logic                ready_n,
    input logic                pdata7
);
    import fsr_pkg::*;

    AST_OE_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_oe) |-> rd_data == 8'h00); // R2

    AST_PROG_STATUS_INV: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_oe) && ($past(st) == ST_PROG || $past(st) == ST_SPROG))
        |-> rd_data == {~$past(pdata7), 7'd0}); // R4

    AST_ERASE_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_oe) && $past(st) == ST_ERASE) |-> rd_data == 8'h00); // R5

    AST_SETTLE_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_oe) && $past(st) == ST_SETTLE) |-> rd_data[6:0] == 7'd0); // R6

    AST_SETTLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        st == ST_SETTLE |=> st == ST_IDLE); // R6

    AST_SUSP_READY: assert property (@(posedge clk) disable iff (rst)
        st == ST_ESUSP |-> ready_n); // R10

    AST_BUSY_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_PROG && st == ST_PROG) |-> $stable(pdata7)); // R12
endmodule

bind flash_status_resp fsr_checker chk_i (
    .clk(clk), .rst(rst), .st(state_q), .rd_oe(rd_oe), .rd_data(rd_data),
    .ready_n(ready_n), .pdata7(pdata_q[7])
);

// File: tb/flash_status_resp_tb_top.sv
`timescale 1ns/1ps
module flash_status_resp_tb_top;
    localparam int PROG_CYC       = 16;
    localparam int ERASE_CYC      = 40;
    localparam int PROT_PROG_CYC  = 6;
    localparam int PROT_ERASE_CYC = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_start = 1'b0;
    logic [5:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic       erase_start = 1'b0;
    logic [3:0] erase_sel = '0;
    logic       susp_req = 1'b0;
    logic [3:0] prot_mask = '0;
    logic       rd_oe = 1'b0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ready_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit pend = 1'b0;
    bit done = 1'b0;
    logic [7:0] q_exp[$];
    string      q_tag[$];
    logic [7:0] emem[64];

    always #5 clk = ~clk;

    flash_status_resp dut_i (
        .clk(clk), .rst(rst), .prog_start(prog_start), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_start(erase_start), .erase_sel(erase_sel),
        .susp_req(susp_req), .prot_mask(prot_mask), .rd_oe(rd_oe), .rd_addr(rd_addr),
        .rd_data(rd_data), .ready_n(ready_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic issue_read(input logic [5:0] a, input logic [7:0] e, input string tag);
        rd_oe   = 1'b1;
        rd_addr = a;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // monitor side
    always @(posedge clk) pend <= rd_oe;

    initial begin
        forever begin
            @(negedge clk);
            if (pend) begin
                if (q_exp.size() == 0) begin
                    chk(1'b0, "scoreboard underflow", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    chk(rd_data == e, t, rd_data, e);
                end
            end
        end
    end

    task automatic start_prog(input logic [5:0] a, input logic [7:0] d);
        rd_oe      = 1'b0;
        prog_addr  = a;
        prog_data  = d;
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
    endtask

    task automatic start_erase(input logic [3:0] m);
        rd_oe       = 1'b0;
        erase_sel   = m;
        erase_start = 1'b1;
        @(negedge clk);
        erase_start = 1'b0;
    endtask

    task automatic busy_loop(input logic [5:0] a, input logic [7:0] st, input int n_exp,
                             input string tag, input int poke_at);
        int n = 0;
        while (ready_n == 1'b0 && n < 2000) begin
            issue_read(a, st, tag);
            erase_start = (n == poke_at);
            n++;
            @(negedge clk);
        end
        erase_start = 1'b0;
        if (n_exp >= 0) chk(n == n_exp, {tag, " busy length"}, n, n_exp);
    endtask

    task automatic drain();
        rd_oe = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_op(input logic [5:0] a, input string tag);
        issue_read(a, {emem[a][7], 7'd0}, {tag, " settle"});
        @(negedge clk);
        issue_read(a, emem[a], {tag, " data"});
        @(negedge clk);
        drain();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            int v;
            v = i * 37 + 5;
            emem[i] = v[7:0];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(ready_n == 1'b1, "R1 ready_n", ready_n, 1);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        issue_read(6'h00, emem[6'h00], "R1 init 0x00"); @(negedge clk);
        issue_read(6'h05, emem[6'h05], "R1 init 0x05"); @(negedge clk);
        issue_read(6'h31, emem[6'h31], "R1 init 0x31"); @(negedge clk);
        drain();
        chk(rd_data == 8'h00, "R2 oe low", rd_data, 0);

        // R3 R4 R12: program bit7=0, erase start poked while busy
        erase_sel = 4'b0010;
        start_prog(6'h05, 8'h3C);
        busy_loop(6'h05, 8'h80, PROG_CYC, "R4 R3", 3);
        emem[6'h05] = 8'h3C;
        finish_op(6'h05, "R6 prog");
        issue_read(6'h12, emem[6'h12], "R12 erase ignored"); @(negedge clk);
        drain();
        chk(ready_n == 1'b1, "R12 no busy", ready_n, 1);

        // R4 status at another address, bit7=1
        start_prog(6'h07, 8'hA5);
        busy_loop(6'h20, 8'h00, PROG_CYC, "R4 other addr", -1);
        emem[6'h07] = 8'hA5;
        finish_op(6'h07, "R6 prog b7");

        // R7 protected program
        prot_mask = 4'b1000;
        start_prog(6'h31, 8'h00);
        busy_loop(6'h31, 8'h80, PROT_PROG_CYC, "R7", -1);
        finish_op(6'h31, "R7 unchanged");

        // R8 fully protected erase
        start_erase(4'b1000);
        busy_loop(6'h31, 8'h00, PROT_ERASE_CYC, "R8", -1);
        finish_op(6'h31, "R8 unchanged");

        // R5 R9 partially protected erase
        start_erase(4'b1010);
        busy_loop(6'h12, 8'h00, ERASE_CYC, "R5 R3", -1);
        for (int i = 16; i < 32; i++) emem[i] = 8'hFF;
        finish_op(6'h12, "R9 erased");
        issue_read(6'h1F, 8'hFF, "R9 erased end"); @(negedge clk);
        issue_read(6'h31, emem[6'h31], "R9 protected kept"); @(negedge clk);
        issue_read(6'h05, emem[6'h05], "R9 unselected kept"); @(negedge clk);
        drain();

        // R10 R11 suspend
        prot_mask = 4'b0000;
        start_erase(4'b0100);
        repeat (5) begin
            issue_read(6'h22, 8'h00, "R5 pre-suspend");
            @(negedge clk);
        end
        susp_req = 1'b1;
        busy_loop(6'h22, 8'h00, 1, "R10 entry", -1);
        chk(ready_n == 1'b1, "R10 ready in suspend", ready_n, 1);
        issue_read(6'h22, 8'h80, "R10 selected sector"); @(negedge clk);
        issue_read(6'h05, emem[6'h05], "R10 other sector"); @(negedge clk);
        drain();
        start_prog(6'h23, 8'h00);
        chk(ready_n == 1'b1, "R11 ignored prog", ready_n, 1);
        @(negedge clk);
        chk(ready_n == 1'b1, "R11 ignored prog later", ready_n, 1);
        start_prog(6'h08, 8'h11);
        busy_loop(6'h08, 8'h80, PROG_CYC, "R11 susp prog", -1);
        emem[6'h08] = 8'h11;
        issue_read(6'h08, 8'h11, "R11 written"); @(negedge clk);
        issue_read(6'h2A, 8'h80, "R11 back in suspend"); @(negedge clk);
        drain();
        chk(ready_n == 1'b1, "R10 still suspended", ready_n, 1);
        susp_req = 1'b0;
        @(negedge clk);
        busy_loop(6'h20, 8'h00, ERASE_CYC - 5, "R10 resume", -1);
        for (int i = 32; i < 48; i++) emem[i] = 8'hFF;
        finish_op(6'h20, "R10 erase done");
        issue_read(6'h08, 8'h11, "R11 kept after erase"); @(negedge clk);
        issue_read(6'h23, 8'hFF, "R10 erased 0x23"); @(negedge clk);
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule